// File: doc/BRIEF.md
# DRAM Command Issue Gate

This block lives in a memory controller next to the command scheduler. It keeps a shadow of every bank in every rank: whether the bank is closed, holds an open row, or has just been refreshed. For each bank it also stores the open row address and the earliest cycle at which an activate, a read, a write or a precharge may next go out. The scheduler offers one candidate command per cycle as a type, rank, bank and row. The gate answers in the same cycle with a combinational flag that says whether that command may be sent now. It raises a separate flag when the command type is not one it knows.

When the scheduler actually sends a command, it pulses the issue strobe with the same candidate still on the inputs. The gate then moves its timing registers forward. The update covers the target bank and, where a rule reaches that far, the other banks of the same rank. Each rank also has a sliding window of four activate timers, so that no more than four activates fall inside one activate window. Each bank has a counter of column accesses since its last activate, and the counter caps how many reads and writes one row may take. A free-running cycle counter is the time base. Every earliest-cycle register is compared against it with an unsigned greater-or-equal test.

Top module: `dcg_issue_gate`

## Requirements
- R1: After reset every bank is closed, every earliest-cycle register is zero, every activate window is empty, and the cycle counter counts up by one per clock. An activate to any bank is therefore issuable in the first cycle after reset.
- R2: An activate (type code 0) is issuable only if all three conditions hold: the bank is closed or refreshed, the cycle has reached the bank's next-activate time, and the rank's window holds fewer than four live activate timers.
- R3: A read (code 1) or a read with auto-precharge (code 2) is issuable only if four conditions hold: the bank holds an open row, the cycle has reached next-read, the candidate row equals the open row, and the bank's access counter is below MAX_ACC.
- R4: A write (code 3) or a write with auto-precharge (code 4) follows the R3 rule, with next-write in place of next-read.
- R5: A precharge (code 5) is issuable only if the bank holds an open row and the cycle has reached next-precharge. A precharge closes the bank.
- R6: A refresh candidate (code 6) is never reported issuable.
- R7: Code 7 is not recognised. It reports not issuable and drives cmd_err high. All other codes drive cmd_err low.
- R8: An issued activate at cycle t opens the row. It sets that bank's next-read and next-write to t+T_RCD, next-precharge to t+T_RAS and next-activate to t+T_RC. It raises next-activate of every other bank in the rank to at least t+T_RRD.
- R9: An issued read at cycle t raises next-read of every bank in the rank to at least t+max(T_CCD,BL/2) and next-write to at least t+T_RD2WR. A write does the same with t+T_WR2RD for next-read and t+max(T_CCD,BL/2) for next-write. The target bank's next-precharge becomes at least t+T_RD2PRE after a read and at least t+T_WR2PRE after a write.
- R10: A read or write with auto-precharge at cycle t closes the bank. It raises the bank's next-activate to at least t+T_RDAP for a read or t+T_WRAP for a write.
- R11: A precharge at cycle t raises the bank's next-activate to at least t+T_RP.
- R12: Each issued activate occupies one slot of its rank's window for exactly T_FAW cycles. A fifth activate in a rank can first issue at the first activate's cycle plus T_FAW.
- R13: The access counter of a bank clears on an activate to that bank and increments on each read or write to it. Once it equals MAX_ACC, further reads and writes to that row are not issuable.
- R14: A refresh issued at cycle t marks every bank of the rank as refreshed and sets their next-activate to exactly t+T_RFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_cmd | input | 3 | Candidate command type code |
| cand_rank | input | RANK_W | Candidate rank |
| cand_bank | input | BANK_W | Candidate bank within the rank |
| cand_row | input | ROW_W | Candidate row address |
| issue | input | 1 | The candidate on the inputs is sent this cycle |
| issuable | output | 1 | Candidate may be sent this cycle |
| cmd_err | output | 1 | Candidate type code is not recognised |

## Verification
Any corruption of a bank's timing registers shows up at the issuable port as an earliest-issue cycle that is too early or too late. It appears the first time that bank or rank is probed, which can be several to a few tens of cycles after the update that went wrong. For that reason the bench searches for the first cycle in which a candidate becomes issuable and compares it with the maximum of all the timing rules that apply. A wrong open row or a wrong access count shows up as a read or write that is wrongly refused or wrongly allowed. A stale activate window shows up as a fifth activate being allowed before the window has drained.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [2:0] {
    C_ACT = 3'd0,
    C_RD  = 3'd1,
    C_RDA = 3'd2,
    C_WR  = 3'd3,
    C_WRA = 3'd4,
    C_PRE = 3'd5,
    C_REF = 3'd6,
    C_BAD = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_OPEN = 2'd1,
    B_REFR = 2'd2
  } bstate_e;
endpackage

// File: rtl/dcg_faw_win.sv
module dcg_faw_win #(
  parameter int SLOTS = 4,
  parameter int T_FAW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic full
);
  localparam int TW = $clog2(T_FAW + 1);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [TW-1:0] LOADV = TW'(T_FAW - 1);

  logic [TW-1:0] tmr [SLOTS];
  logic [SLOTS-1:0] busy;
  logic [SW-1:0] free_idx;
  int unsigned live;

  always_comb begin
    live = 0;
    free_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (busy[s]) live = live + 1;
      else free_idx = SW'(s);
    end
    full = (live >= SLOTS);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign busy[s] = (tmr[s] != '0);
    always_ff @(posedge clk) begin
      if (rst) tmr[s] <= '0;
      else if (load && !full && (free_idx == SW'(s))) tmr[s] <= LOADV;
      else if (tmr[s] != '0) tmr[s] <= tmr[s] - 1'b1;
    end
  end

  AST_FAW_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (load && !full && T_FAW > 1) |=> ($countones(busy) != 0)); // R12
  AST_FAW_DRAIN: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($countones(busy) <= $past($countones(busy)))); // R12
endmodule

// File: rtl/dcg_bank.sv
module dcg_bank
  import dcg_pkg::*;
#(
  parameter int CW       = 32,
  parameter int ROW_W    = 14,
  parameter int ACC_W    = 4,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 8,
  parameter int T_RC     = 11,
  parameter int T_RP     = 3,
  parameter int T_RRD    = 2,
  parameter int T_CCDE   = 4,
  parameter int T_RD2PRE = 2,
  parameter int T_WR2PRE = 6,
  parameter int T_RD2WR  = 5,
  parameter int T_WR2RD  = 7,
  parameter int T_RDAP   = 9,
  parameter int T_WRAP   = 12,
  parameter int T_RFC    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    now,
  input  cmd_e             cmd,
  input  logic [ROW_W-1:0] row,
  input  logic             sel_rank,
  input  logic             sel_bank,
  output bstate_e          st_q,
  output logic [ROW_W-1:0] row_q,
  output logic [CW-1:0]    n_act,
  output logic [CW-1:0]    n_rd,
  output logic [CW-1:0]    n_wr,
  output logic [CW-1:0]    n_pre,
  output logic [ACC_W-1:0] acc_q
);
  localparam logic [CW-1:0] D_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] D_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] D_RC  = CW'(T_RC);
  localparam logic [CW-1:0] D_RP  = CW'(T_RP);
  localparam logic [CW-1:0] D_RRD = CW'(T_RRD);
  localparam logic [CW-1:0] D_CCD = CW'(T_CCDE);
  localparam logic [CW-1:0] D_R2P = CW'(T_RD2PRE);
  localparam logic [CW-1:0] D_W2P = CW'(T_WR2PRE);
  localparam logic [CW-1:0] D_R2W = CW'(T_RD2WR);
  localparam logic [CW-1:0] D_W2R = CW'(T_WR2RD);
  localparam logic [CW-1:0] D_RAP = CW'(T_RDAP);
  localparam logic [CW-1:0] D_WAP = CW'(T_WRAP);
  localparam logic [CW-1:0] D_RFC = CW'(T_RFC);

  function automatic logic [CW-1:0] later(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic hit;
  assign hit = sel_rank && sel_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= B_IDLE;
      row_q <= '0;
      n_act <= '0;
      n_rd  <= '0;
      n_wr  <= '0;
      n_pre <= '0;
      acc_q <= '0;
    end else if (sel_rank) begin
      case (cmd)
        C_ACT: begin
          if (sel_bank) begin
            st_q  <= B_OPEN;
            row_q <= row;
            n_act <= now + D_RC;
            n_rd  <= now + D_RCD;
            n_wr  <= now + D_RCD;
            n_pre <= now + D_RAS;
            acc_q <= '0;
          end else begin
            n_act <= later(n_act, now + D_RRD);
          end
        end
        C_RD, C_RDA: begin
          n_rd <= later(n_rd, now + D_CCD);
          n_wr <= later(n_wr, now + D_R2W);
          if (sel_bank) begin
            acc_q <= acc_q + 1'b1;
            if (cmd == C_RD) n_pre <= later(n_pre, now + D_R2P);
            else begin
              st_q  <= B_IDLE;
              n_act <= later(n_act, now + D_RAP);
            end
          end
        end
        C_WR, C_WRA: begin
          n_rd <= later(n_rd, now + D_W2R);
          n_wr <= later(n_wr, now + D_CCD);
          if (sel_bank) begin
            acc_q <= acc_q + 1'b1;
            if (cmd == C_WR) n_pre <= later(n_pre, now + D_W2P);
            else begin
              st_q  <= B_IDLE;
              n_act <= later(n_act, now + D_WAP);
            end
          end
        end
        C_PRE: begin
          if (sel_bank) begin
            st_q  <= B_IDLE;
            n_act <= later(n_act, now + D_RP);
          end
        end
        C_REF: begin
          st_q  <= B_REFR;
          n_act <= now + D_RFC;
        end
        default: ;
      endcase
    end
  end

  AST_OPEN_ON_ACT: assert property (@(posedge clk) disable iff (rst)
    (hit && cmd == C_ACT) |=> (st_q == B_OPEN && acc_q == '0)); // R13
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_OPEN && !(hit && cmd == C_ACT)) |=> $stable(row_q)); // R3
  AST_CLOSE_BANK: assert property (@(posedge clk) disable iff (rst)
    (hit && (cmd == C_PRE || cmd == C_RDA || cmd == C_WRA)) |=> (st_q == B_IDLE)); // R10
  AST_RD_MONO: assert property (@(posedge clk) disable iff (rst)
    !(hit && cmd == C_ACT) |=> (n_rd >= $past(n_rd))); // R9
endmodule

// File: rtl/dcg_issue_gate.sv
module dcg_issue_gate
  import dcg_pkg::*;
#(
  parameter int CW       = 32,
  parameter int RANK_W   = 1,
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 14,
  parameter int FAW_ACTS = 4,
  parameter int MAX_ACC  = 3,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 8,
  parameter int T_RC     = 11,
  parameter int T_RP     = 3,
  parameter int T_RRD    = 2,
  parameter int T_FAW    = 16,
  parameter int T_CCD    = 2,
  parameter int BL       = 8,
  parameter int T_RD2PRE = 2,
  parameter int T_WR2PRE = 6,
  parameter int T_RD2WR  = 5,
  parameter int T_WR2RD  = 7,
  parameter int T_RDAP   = 9,
  parameter int T_WRAP   = 12,
  parameter int T_RFC    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cand_cmd,
  input  logic [RANK_W-1:0] cand_rank,
  input  logic [BANK_W-1:0] cand_bank,
  input  logic [ROW_W-1:0]  cand_row,
  input  logic              issue,
  output logic              issuable,
  output logic              cmd_err
);
  localparam int RANKS  = 2 ** RANK_W;
  localparam int BANKS  = 2 ** BANK_W;
  localparam int NB     = RANKS * BANKS;
  localparam int IW     = RANK_W + BANK_W;
  localparam int ACC_W  = $clog2(MAX_ACC + 1);
  localparam int T_CCDE = (T_CCD > BL / 2) ? T_CCD : BL / 2;
  localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(MAX_ACC);

  cmd_e cmd;
  assign cmd = cmd_e'(cand_cmd);

  logic [CW-1:0] now_q;
  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  bstate_e          st    [NB];
  logic [ROW_W-1:0] orow  [NB];
  logic [CW-1:0]    n_act [NB];
  logic [CW-1:0]    n_rd  [NB];
  logic [CW-1:0]    n_wr  [NB];
  logic [CW-1:0]    n_pre [NB];
  logic [ACC_W-1:0] acc   [NB];
  logic [RANKS-1:0] faw_full;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic rk_sel;
    assign rk_sel = issue && (cand_rank == RANK_W'(r));

    dcg_faw_win #(.SLOTS(FAW_ACTS), .T_FAW(T_FAW)) u_faw (
      .clk  (clk),
      .rst  (rst),
      .load (rk_sel && cmd == C_ACT),
      .full (faw_full[r])
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int K = r * BANKS + b;
      dcg_bank #(
        .CW(CW), .ROW_W(ROW_W), .ACC_W(ACC_W),
        .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
        .T_RRD(T_RRD), .T_CCDE(T_CCDE), .T_RD2PRE(T_RD2PRE),
        .T_WR2PRE(T_WR2PRE), .T_RD2WR(T_RD2WR), .T_WR2RD(T_WR2RD),
        .T_RDAP(T_RDAP), .T_WRAP(T_WRAP), .T_RFC(T_RFC)
      ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .now      (now_q),
        .cmd      (cmd),
        .row      (cand_row),
        .sel_rank (rk_sel),
        .sel_bank (cand_bank == BANK_W'(b)),
        .st_q     (st[K]),
        .row_q    (orow[K]),
        .n_act    (n_act[K]),
        .n_rd     (n_rd[K]),
        .n_wr     (n_wr[K]),
        .n_pre    (n_pre[K]),
        .acc_q    (acc[K])
      );
    end
  end

  logic [IW-1:0] idx;
  logic          row_ok;
  assign idx    = {cand_rank, cand_bank};
  assign row_ok = (orow[idx] == cand_row) && (acc[idx] < ACC_LIM);

  always_comb begin
    issuable = 1'b0;
    case (cmd)
      C_ACT:
        issuable = (st[idx] == B_IDLE || st[idx] == B_REFR) &&
                   (now_q >= n_act[idx]) && !faw_full[cand_rank];
      C_RD, C_RDA:
        issuable = (st[idx] == B_OPEN) && (now_q >= n_rd[idx]) && row_ok;
      C_WR, C_WRA:
        issuable = (st[idx] == B_OPEN) && (now_q >= n_wr[idx]) && row_ok;
      C_PRE:
        issuable = (st[idx] == B_OPEN) && (now_q >= n_pre[idx]);
      default:
        issuable = 1'b0;
    endcase
  end

  assign cmd_err = (cmd == C_BAD);

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (now_q == $past(now_q) + 1'b1)); // R1
  AST_ISSUE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (issue && cmd != C_REF && cmd != C_BAD) |-> issuable); // R2
  AST_BAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> !issuable); // R7
  AST_REF_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF) |-> (!issuable && !cmd_err)); // R6
endmodule

// File: tb/dcg_issue_gate_tb_top.sv
`timescale 1ns/1ps
module dcg_issue_gate_tb_top;
  localparam int RCD = 3, RAS = 8, RC = 11, RP = 3, RRD = 2, FAW = 16;
  localparam int CCDE = 4, R2P = 2, W2P = 6, R2W = 5, W2R = 7;
  localparam int RAP = 9, WAP = 12, RFC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cand_cmd = 3'd0;
  logic [0:0] cand_rank = '0;
  logic [1:0] cand_bank = '0;
  logic [3:0] cand_row = '0;
  logic issue = 1'b0;
  logic issuable, cmd_err;

  int total = 0;
  int bad = 0;
  int now_b = 0;

  always #2 clk = ~clk;

  always @(posedge clk) now_b <= rst ? 0 : now_b + 1;

  dcg_issue_gate #(
    .CW(32), .RANK_W(1), .BANK_W(2), .ROW_W(4), .FAW_ACTS(4), .MAX_ACC(3),
    .T_RCD(RCD), .T_RAS(RAS), .T_RC(RC), .T_RP(RP), .T_RRD(RRD), .T_FAW(FAW),
    .T_CCD(2), .BL(8), .T_RD2PRE(R2P), .T_WR2PRE(W2P), .T_RD2WR(R2W),
    .T_WR2RD(W2R), .T_RDAP(RAP), .T_WRAP(WAP), .T_RFC(RFC)
  ) dut_i (
    .clk(clk), .rst(rst), .cand_cmd(cand_cmd), .cand_rank(cand_rank),
    .cand_bank(cand_bank), .cand_row(cand_row), .issue(issue),
    .issuable(issuable), .cmd_err(cmd_err)
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic drive(input int c, input int r, input int b, input int row);
    cand_cmd  = 3'(c);
    cand_rank = 1'(r);
    cand_bank = 2'(b);
    cand_row  = 4'(row);
  endtask

  task automatic peek(input int c, input int r, input int b, input int row, output int v);
    @(negedge clk);
    drive(c, r, b, row);
    #1;
    v = int'(issuable);
  endtask

  task automatic probe(input int c, input int r, input int b, input int row, output int t);
    t = -1;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      drive(c, r, b, row);
      #1;
      if (issuable) begin
        t = now_b;
        break;
      end
    end
  endtask

  task automatic fire(output int t);
    issue = 1'b1;
    t = now_b;
    @(posedge clk);
    #1;
    issue = 1'b0;
  endtask

  task automatic send(input int c, input int r, input int b, input int row, output int t);
    @(negedge clk);
    drive(c, r, b, row);
    #1;
    fire(t);
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, t, tA, tB, tR, tW, tR2, tP, tA2, tC, tX, tD, tY, t0, t1, t2, t3, tP1, tF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: clean state after reset
    peek(0, 0, 0, 0, v); chk("R1 act after reset", v, 1);
    chk("R7 no error on act", int'(cmd_err), 0);
    peek(1, 0, 0, 0, v); chk("R3 read to closed bank", v, 0);

    send(0, 0, 0, 5, tA);
    probe(0, 0, 1, 2, t); chk("R8 act-to-act other bank", t, tA + RRD);
    fire(tB);
    probe(1, 0, 0, 5, t); chk("R8 act-to-read", t, tA + RCD);
    peek(1, 0, 0, 6, v); chk("R3 row mismatch", v, 0);
    peek(0, 0, 0, 5, v); chk("R2 act to open bank", v, 0);
    send(1, 0, 0, 5, tR);
    probe(1, 0, 1, 2, t); chk("R9 read-to-read other bank", t, mx(tB + RCD, tR + CCDE));
    probe(3, 0, 0, 5, t); chk("R9 read-to-write", t, mx(tA + RCD, tR + R2W));
    fire(tW);
    probe(5, 0, 0, 5, t); chk("R5 precharge earliest", t, mx(mx(tA + RAS, tR + R2P), tW + W2P));
    probe(1, 0, 0, 5, t); chk("R9 write-to-read", t, mx(tW + W2R, tR + CCDE));
    fire(tR2);

    repeat (12) @(posedge clk);
    peek(1, 0, 0, 5, v); chk("R13 read over limit", v, 0);
    peek(3, 0, 0, 5, v); chk("R13 write over limit", v, 0);
    peek(5, 0, 0, 5, v); chk("R5 precharge allowed", v, 1);
    send(5, 0, 0, 5, tP);
    peek(1, 0, 0, 5, v); chk("R5 read after precharge", v, 0);
    probe(0, 0, 0, 7, t); chk("R11 precharge-to-act", t, mx(tA + RC, tP + RP));
    fire(tA2);
    probe(1, 0, 0, 7, t); chk("R13 counter cleared", t, tA2 + RCD);

    // auto-precharge on rank 1
    send(0, 1, 0, 3, tC);
    probe(2, 1, 0, 3, t); chk("R3 read-ap earliest", t, tC + RCD);
    fire(tX);
    peek(1, 1, 0, 3, v); chk("R10 read after read-ap", v, 0);
    send(0, 1, 1, 1, tD);
    probe(4, 1, 1, 1, t); chk("R4 write-ap earliest", t, mx(tD + RCD, tX + R2W));
    fire(tY);
    probe(0, 1, 0, 3, t); chk("R10 read-ap to act", t, mx(mx(tC + RC, tX + RAP), tD + RRD));
    probe(0, 1, 1, 1, t); chk("R10 write-ap to act", t, mx(tD + RC, tY + WAP));

    // R12: activate window on rank 1
    repeat (20) @(posedge clk);
    probe(0, 1, 0, 1, t); fire(t0);
    probe(0, 1, 1, 1, t); chk("R8 window act 2", t, t0 + RRD); fire(t1);
    probe(0, 1, 2, 1, t); chk("R8 window act 3", t, t1 + RRD); fire(t2);
    probe(0, 1, 3, 1, t); chk("R8 window act 4", t, t2 + RRD); fire(t3);
    probe(5, 1, 0, 1, t); chk("R5 window precharge", t, t0 + RAS); fire(tP1);
    probe(0, 1, 0, 2, t);
    chk("R12 fifth act", t, mx(mx(t0 + RC, tP1 + RP), mx(t0 + FAW, t3 + RRD)));

    // R14 / R6: refresh on rank 0
    probe(5, 0, 0, 7, t); fire(t);
    probe(5, 0, 1, 2, t); fire(t);
    peek(6, 0, 0, 0, v); chk("R6 refresh never issuable", v, 0);
    chk("R7 no error on refresh", int'(cmd_err), 0);
    send(6, 0, 0, 0, tF);
    probe(0, 0, 2, 4, t); chk("R14 refresh-to-act", t, tF + RFC);
    peek(0, 0, 0, 4, v); chk("R2 act in refreshed bank", v, 1);

    // R7: unknown type code
    peek(7, 0, 3, 0, v); chk("R7 unknown not issuable", v, 0);
    chk("R7 unknown flags error", int'(cmd_err), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule